// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block is the requester (bridge) end of an APB link with a single completer. A local agent gives it one read or write command at a time through a valid/ready handshake. The block runs each command as an APB transfer: one Setup cycle, then as many Access cycles as the completer requests by holding PREADY low. Every bus output comes straight from a register. Address, direction, protection, write data and byte strobes are loaded when a command is accepted. They hold steady until the completion edge.

Read data and the slave-error flag are sampled only on the true completion edge, where select, enable and ready are all high. Whatever the completer drives during wait cycles is ignored. The result comes back as a one-cycle response pulse. A command that is waiting when a transfer completes is accepted on that same edge, so select stays high and the next Setup cycle follows straight away. With no command waiting, the bus goes idle.

Top module: `apb_req_ctrl`

## Requirements
- R1: After synchronous reset, psel, penable and rsp_valid are 0 and cmd_ready is 1.
- R2: Each accepted command gives exactly one Setup cycle (psel=1, penable=0) on the cycle after acceptance. The Access phase (psel=1, penable=1) follows on the next cycle.
- R3: While the Access phase waits (pready=0), paddr, pwrite, pstrb, pprot, psel and penable stay unchanged.
- R4: rsp_rdata for a read equals the value on prdata at the edge where psel, penable and pready are all 1. Values driven on prdata during wait cycles never reach rsp_rdata.
- R5: rsp_err equals pslverr at the completion edge. A pslverr that is high during wait cycles has no effect.
- R6: For a read (pwrite=0), pstrb and pwdata are all zeros for the whole transfer.
- R7: For a write, pwrite=1 and paddr, pwdata, pstrb and pprot carry the command's values for the whole transfer. A direction change happens only between transfers.
- R8: rsp_valid is a one-cycle pulse in the cycle after the completion edge. For a write, rsp_rdata is 0. With no wait states, the pulse is seen three cycles after the accepting edge, plus one cycle per wait state.
- R9: If a command is presented at a completion edge, it is accepted on that edge. psel stays 1 and penable is 0 for exactly one cycle before the next Access phase.
- R10: If no command is presented at a completion edge, psel and penable are both 0 in the next cycle.
- R11: cmd_ready is 1 only when the bus is idle or at a completion edge. While a transfer is in Setup or in a wait cycle, a presented command is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Write byte-lane enables |
| cmd_prot | input | 3 | Protection attributes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Captured read data (0 for writes) |
| rsp_err | output | 1 | Captured slave error |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access phase marker |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobes |
| pprot | output | 3 | Bus protection |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
Reads are run against a completer model that takes zero and several wait states. During wait cycles it drives garbage read data and a raised error line. This shows whether data is taken at the first Access cycle or at the true completion edge. A zero-wait case alone could not show that difference. Back-to-back pairs with a command held waiting are compared against pairs with a gap, which shows whether select stays high and enable drops for exactly one cycle. A read followed by a write checks that strobes and write data are cleared on reads and carried on writes. Error and non-error addresses check that the error flag is taken only at completion.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/apb_req_seq.sv
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic        pready,
  output xfer_state_t state_d,
  output logic        cmd_ready,
  output logic        accept,
  output logic        complete
);
  xfer_state_t state_q;

  assign complete  = (state_q == ST_ACCESS) && pready;
  assign cmd_ready = (state_q == ST_IDLE) || complete;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready) state_d = accept ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/apb_req_drv.sv
module apb_req_drv
  import apb_req_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  xfer_state_t       state_d,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [STRB_W-1:0] cmd_strb,
  input  logic [2:0]        cmd_prot,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot
);
  logic [DATA_W-1:0] wdata_m;
  logic [STRB_W-1:0] strb_m;

  // Per-lane clearing of write payload on reads.
  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    assign wdata_m[g*8 +: 8] = cmd_write ? cmd_wdata[g*8 +: 8] : 8'h00;
    assign strb_m[g]         = cmd_write & cmd_strb[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psel    <= 1'b0;
      penable <= 1'b0;
    end else begin
      psel    <= (state_d != ST_IDLE);
      penable <= (state_d == ST_ACCESS);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      pwdata <= '0;
      pstrb  <= '0;
      pprot  <= '0;
    end else if (accept) begin
      paddr  <= cmd_addr;
      pwrite <= cmd_write;
      pwdata <= wdata_m;
      pstrb  <= strb_m;
      pprot  <= cmd_prot;
    end
  end
endmodule

// File: rtl/apb_req_rsp.sv
module apb_req_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              complete,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= complete;
      if (complete) begin
        rsp_rdata <= pwrite ? '0 : prdata;
        rsp_err   <= pslverr;
      end
    end
  end
endmodule

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl
  import apb_req_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [STRB_W-1:0] cmd_strb,
  input  logic [2:0]        cmd_prot,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  xfer_state_t state_d;
  logic        accept;
  logic        complete;

  apb_req_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .pready    (pready),
    .state_d   (state_d),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .complete  (complete)
  );

  apb_req_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .state_d   (state_d),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_strb  (cmd_strb),
    .cmd_prot  (cmd_prot),
    .psel      (psel),
    .penable   (penable),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pstrb     (pstrb),
    .pprot     (pprot)
  );

  apb_req_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .complete  (complete),
    .pwrite    (pwrite),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/apb_req_chk.sv
module apb_req_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              psel,
  input logic              penable,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic [STRB_W-1:0] pstrb,
  input logic [2:0]        pprot,
  input logic              pready,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr
);
  p_setup_then_access_r2: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));

  p_enable_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);

  p_hold_in_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) &&
      $stable(pwrite) && $stable(pstrb) && $stable(pprot)));

  p_rdata_at_done_r4: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready && !pwrite) |=> (rsp_rdata == $past(prdata)));

  p_err_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready) |=> (rsp_err == $past(pslverr)));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite) |-> (pstrb == '0 && pwdata == '0));

  p_rsp_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready) |=> rsp_valid);

  p_rsp_only_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(psel && penable && pready));

  p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready && cmd_valid) |=> (psel && !penable));

  p_go_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready && !cmd_valid) |=> (!psel && !penable));

  p_ready_window_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!psel || (penable && pready)));
endmodule

bind apb_req_ctrl apb_req_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .psel      (psel),
  .penable   (penable),
  .paddr     (paddr),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pstrb     (pstrb),
  .pprot     (pprot),
  .pready    (pready),
  .prdata    (prdata),
  .pslverr   (pslverr)
);

// File: tb/test_apb_req_ctrl.sv
module test_apb_req_ctrl;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam logic [AW-1:0] ERR_ADDR = 12'hBAD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_strb = '0;
  logic [2:0]    cmd_prot = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          psel, penable, pwrite, pready, pslverr;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic [SW-1:0] pstrb;
  logic [2:0]    pprot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  apb_req_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_apb_req_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_strb(cmd_strb), .cmd_prot(cmd_prot), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .psel(psel), .penable(penable),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
    .pprot(pprot), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  // Completer model with programmable wait states
  int waits = 0;
  int cnt   = 0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [SW-1:0] wr_strb;
  logic [2:0]    wr_prot;

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    return 32'hA500_0000 ^ {20'h0, a};
  endfunction

  assign pready  = psel && penable && (cnt == waits);
  assign prdata  = pready ? exp_rd(paddr) : (32'hFFFF_0000 | cnt);
  assign pslverr = psel && penable && (pready ? (paddr == ERR_ADDR) : 1'b1);

  always @(posedge clk) begin
    if (rst || !(psel && penable) || pready) cnt <= 0;
    else cnt <= cnt + 1;
    if (psel && penable && pready && pwrite) begin
      wr_addr <= paddr; wr_data <= pwdata; wr_strb <= pstrb; wr_prot <= pprot;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus-rule monitor sampled at negedges
  logic          hold_pend = 1'b0;
  logic [AW-1:0] h_addr;
  logic          h_write;
  logic [SW-1:0] h_strb;
  logic [2:0]    h_prot;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        chk(psel && penable && paddr == h_addr && pwrite == h_write &&
            pstrb == h_strb && pprot == h_prot, "R3 hold in wait",
            {20'h0, paddr}, {20'h0, h_addr});
      end
      hold_pend = psel && penable && !pready;
      h_addr = paddr; h_write = pwrite; h_strb = pstrb; h_prot = pprot;
      if (psel && !pwrite)
        chk(pstrb == '0 && pwdata == '0, "R6 read clears strb/wdata",
            pwdata, 32'h0);
      if (psel && !(penable && pready))
        chk(!cmd_ready, "R11 ready low mid-transfer", {31'h0, cmd_ready}, 32'h0);
    end
  end

  // Issue one command and wait for its response; returns latency in cycles.
  task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, input logic [2:0] p,
                        output logic [DW-1:0] rd, output logic er, output int lat);
    @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_strb = s; cmd_prot = p;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    chk(psel && !penable, "R2 setup cycle", {30'h0, psel, penable}, 32'h2);
    @(negedge clk);
    lat = 2;
    chk(psel && penable, "R2 access cycle", {30'h0, psel, penable}, 32'h3);
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; er = rsp_err;
    chk(!psel && !penable, "R10 idle after done", {30'h0, psel, penable}, 32'h0);
    @(negedge clk);
    chk(!rsp_valid, "R8 response is one pulse", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset();
    chk(!psel && !penable && !rsp_valid && cmd_ready, "R1 reset state",
        {28'h0, psel, penable, rsp_valid, cmd_ready}, 32'h1);
  endtask

  task automatic t_read(input int w, input logic [AW-1:0] a);
    logic [DW-1:0] rd; logic er; int lat;
    waits = w;
    do_cmd(1'b0, a, 32'h1234_5678, 4'hF, 3'h2, rd, er, lat);
    chk(rd == exp_rd(a), "R4 read data at completion", rd, exp_rd(a));
    chk(!er, "R5 no error from wait-cycle pslverr", {31'h0, er}, 32'h0);
    chk(lat == 3 + w, "R8 response latency", lat, 3 + w);
  endtask

  task automatic t_error(input int w);
    logic [DW-1:0] rd; logic er; int lat;
    waits = w;
    do_cmd(1'b0, ERR_ADDR, '0, '0, 3'h0, rd, er, lat);
    chk(er, "R5 error captured", {31'h0, er}, 32'h1);
    chk(rd == exp_rd(ERR_ADDR), "R4 read data with error", rd, exp_rd(ERR_ADDR));
  endtask

  task automatic t_rmw();
    logic [DW-1:0] rd, rd2; logic er; int lat;
    waits = 2;
    do_cmd(1'b0, 12'h040, '0, '0, 3'h1, rd, er, lat);
    chk(rd == exp_rd(12'h040), "R4 rmw read", rd, exp_rd(12'h040));
    do_cmd(1'b1, 12'h040, rd ^ 32'h0000_00FF, 4'b0101, 3'h5, rd2, er, lat);
    chk(wr_addr == 12'h040 && wr_prot == 3'h5, "R7 write addr/prot",
        {17'h0, wr_prot, wr_addr}, {17'h0, 3'h5, 12'h040});
    chk(wr_data == (exp_rd(12'h040) ^ 32'h0000_00FF), "R7 write data",
        wr_data, exp_rd(12'h040) ^ 32'h0000_00FF);
    chk(wr_strb == 4'b0101, "R7 write strobes", {28'h0, wr_strb}, 32'h5);
    chk(rd2 == '0, "R8 write returns zero rdata", rd2, 32'h0);
    chk(lat == 5, "R8 write latency", lat, 5);
  endtask

  // Two reads with one wait state each, second held waiting.
  task automatic t_b2b();
    logic [1:0] exp_pat [7];
    logic [1:0] got;
    logic [DW-1:0] r1, r2;
    bit drop = 1'b0;
    int nrsp = 0;
    exp_pat = '{2'b10, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11, 2'b00};
    waits = 1;
    r1 = '0; r2 = '0;
    @(negedge clk);
    cmd_write = 1'b0; cmd_addr = 12'h100; cmd_strb = '0; cmd_prot = 3'h0;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      got = {psel, penable};
      if (i == 0) cmd_addr = 12'h204;
      if (rsp_valid) begin
        if (nrsp == 0) r1 = rsp_rdata; else r2 = rsp_rdata;
        nrsp++;
      end
      if (drop) cmd_valid = 1'b0;
      drop = (i > 0) && cmd_valid && cmd_ready;
      chk(got == exp_pat[i], (i == 3) ? "R9 one setup between" :
          (i == 6) ? "R10 idle after pair" : "R9 pair sequence",
          {30'h0, got}, {30'h0, exp_pat[i]});
    end
    cmd_valid = 1'b0;
    chk(nrsp == 2, "R9 two responses", nrsp, 2);
    chk(r1 == exp_rd(12'h100), "R4 first of pair", r1, exp_rd(12'h100));
    chk(r2 == exp_rd(12'h204), "R4 second of pair", r2, exp_rd(12'h204));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(0, 12'h010);
    t_read(3, 12'h014);
    t_read(1, 12'hFFC);
    t_error(0);
    t_error(2);
    t_rmw();
    t_b2b();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule